// File: doc/BRIEF.md
# ADC Mode Register and Conversion Sequencer

This block is the control front end of a successive-approximation converter. A CPU programs an 8-bit mode register, either with a whole-byte write or by setting or clearing one bit. The register holds a run bit, a three-bit rate code and an enable for the boost reference generator. Bits 6, 2 and 1 always read as zero.

The sequencer runs from the stored value. While the run bit is 1 and the rate code is legal, it repeats fixed-length conversions and marks each with a one-cycle start pulse and a one-cycle done pulse. The conversion length is a multiple of the main clock, picked by the rate code. Two codes are forbidden. They block conversion and raise an error flag. The rate bits cannot be changed while the run bit is 1.

A warm-up timer counts out the settling time of the boost reference. The count is longer when the high-reference input is low and shorter when it is high. Every done pulse reports whether the reference had settled when that conversion began.

Top module: `adc_ctl_seq`

## Requirements
- R1: After reset the register reads 0x00 and conv_start, conv_done, result_valid, ref_ready and cfg_error are all 0.
- R2: A byte write (wr_en) stores wr_data with bits 6, 2 and 1 forced to 0. rd_data shows the register while rd_en is 1 and is 0x00 otherwise.
- R3: A single-bit access sets (bit_set) or clears (bit_clr) the bit at bit_idx. Precedence is wr_en, then bit_set, then bit_clr. Accesses to bits 6, 2 and 1 leave them 0.
- R4: When the stored run bit (bit 7) is 1 before an access, the rate field (bits 5..3) keeps its old value. The other bits still take the access.
- R5: Rate codes give conversion lengths in units of UNIT cycles: 000 is 12 units, 001 is 10, 010 is 8, 100 is 6, 101 is 5 and 110 is 4. With the default UNIT of 24 these are 288, 240, 192, 144, 120 and 96 cycles.
- R6: The first conv_start comes one cycle after the run bit is stored. A conv_done follows exactly one conversion length after each conv_start. In that same cycle the next conv_start is issued if the run bit is still 1.
- R7: While the stored rate code is 011 or 111, cfg_error is 1 and no conv_start is issued.
- R8: ref_ready rises WARM_NORM cycles after the edge that stores bit 0 = 1 (WARM_HI cycles when hi_ref is 1). It falls one cycle after bit 0 is stored as 0.
- R9: result_valid is 1 only together with conv_done. It equals the ref_ready value seen when that conversion started.
- R10: Storing the run bit as 0 stops the sequencer in the next cycle. The conversion in progress gives no conv_done and no new conv_start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit selected by a single-bit access |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Register read data (0x00 when rd_en is 0) |
| hi_ref | input | 1 | High reference voltage status, selects the short warm-up |
| conv_start | output | 1 | One-cycle pulse at the start of a conversion |
| conv_done | output | 1 | One-cycle pulse at the end of a conversion |
| result_valid | output | 1 | The conversion just finished began with a settled reference |
| ref_ready | output | 1 | Boost reference warm-up complete |
| cfg_error | output | 1 | Stored rate code is forbidden |

## Verification
The assertions check these rules on every cycle:
- The rate field holds while the run bit is set.
- The reserved bits stay zero.
- Start pulses appear only after an enabled, legal setting and never while cfg_error is high.
- result_valid never appears without conv_done, and done pulses are single cycles.
- ref_ready drops once the reference enable is clear.

The bench scenarios cover what needs a measured interval or a history:
- the exact conversion length for each rate code;
- the warm-up count under both reference levels;
- the valid flag on successive results after a cold enable;
- the absence of a done pulse after a mid-conversion stop.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  localparam int EN_BIT   = 7;
  localparam int REF_BIT  = 0;
  localparam int RATE_LO  = 3;
  localparam int RATE_W   = 3;
  localparam int MAX_MULT = 12;

  // Bits that hold state; 6, 2 and 1 are always stored as zero.
  localparam logic [7:0] KEEP_MASK = 8'b1011_1001;

  // Conversion length in units of the UNIT parameter; 0 marks a forbidden code.
  function automatic int unsigned rate_mult(input logic [RATE_W-1:0] code);
    case (code)
      3'b000:  return 12;
      3'b001:  return 10;
      3'b010:  return 8;
      3'b100:  return 6;
      3'b101:  return 5;
      3'b110:  return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic rate_forbidden(input logic [RATE_W-1:0] code);
    return rate_mult(code) == 0;
  endfunction

  // Next register value for one access cycle.
  function automatic logic [7:0] mode_next(
    input logic [7:0] cur,
    input logic       wr,
    input logic [7:0] data,
    input logic       set,
    input logic       clr,
    input logic [2:0] idx
  );
    logic [7:0] cand;
    cand = cur;
    if (wr)       cand = data;
    else if (set) cand[idx] = 1'b1;
    else if (clr) cand[idx] = 1'b0;
    cand = cand & KEEP_MASK;
    if (cur[EN_BIT])
      cand[RATE_LO +: RATE_W] = cur[RATE_LO +: RATE_W];
    return cand;
  endfunction

endpackage

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
  import adc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       bit_set,
  input  logic       bit_clr,
  input  logic [2:0] bit_idx,
  output logic [7:0] mode_q
);

  logic [7:0] mode_d;

  always_comb begin
    mode_d = mode_next(mode_q, wr_en, wr_data, bit_set, bit_clr, bit_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

endmodule

// File: rtl/adc_warmup.sv
module adc_warmup #(
  parameter int unsigned WARM_NORM = 340,
  parameter int unsigned WARM_HI   = 280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic hi_ref,
  output logic ref_ready
);

  localparam int unsigned MAXW  = (WARM_NORM > WARM_HI) ? WARM_NORM : WARM_HI;
  localparam int          CNT_W = $clog2(MAXW + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             expire;

  assign target = hi_ref ? CNT_W'(WARM_HI) : CNT_W'(WARM_NORM);
  assign expire = (cnt >= target - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !ref_en) begin
      cnt       <= '0;
      ref_ready <= 1'b0;
    end else if (!ref_ready) begin
      if (expire) ref_ready <= 1'b1;
      else        cnt       <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctl_pkg::*;
#(
  parameter int unsigned UNIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              ref_ready,
  output logic              conv_start,
  output logic              conv_done,
  output logic              result_valid,
  output logic              cfg_error
);

  localparam int LEN_W = $clog2(MAX_MULT * UNIT + 1);

  logic [LEN_W-1:0] len_cur;
  logic [LEN_W-1:0] cnt;
  logic             busy;
  logic             vld_cap;
  logic             run_ok;
  logic             last;

  assign len_cur   = LEN_W'(rate_mult(rate_code) * UNIT);
  assign cfg_error = rate_forbidden(rate_code);
  assign run_ok    = run_en && !cfg_error;
  assign last      = busy && (cnt == len_cur - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cnt          <= '0;
      vld_cap      <= 1'b0;
      conv_start   <= 1'b0;
      conv_done    <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      conv_start   <= 1'b0;
      conv_done    <= 1'b0;
      result_valid <= 1'b0;
      if (!run_ok) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (!busy || last) begin
        busy       <= 1'b1;
        cnt        <= '0;
        conv_start <= 1'b1;
        vld_cap    <= ref_ready;
        if (busy) begin
          conv_done    <= 1'b1;
          result_valid <= vld_cap;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
#(
  parameter int unsigned UNIT      = 24,
  parameter int unsigned WARM_NORM = 340,
  parameter int unsigned WARM_HI   = 280
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       bit_set,
  input  logic       bit_clr,
  input  logic [2:0] bit_idx,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       hi_ref,
  output logic       conv_start,
  output logic       conv_done,
  output logic       result_valid,
  output logic       ref_ready,
  output logic       cfg_error
);

  logic [7:0]        mode_q;
  logic [RATE_W-1:0] rate_code;

  assign rate_code = mode_q[RATE_LO +: RATE_W];
  assign rd_data   = rd_en ? mode_q : 8'h00;

  adc_mode_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .bit_set (bit_set),
    .bit_clr (bit_clr),
    .bit_idx (bit_idx),
    .mode_q  (mode_q)
  );

  adc_warmup #(
    .WARM_NORM (WARM_NORM),
    .WARM_HI   (WARM_HI)
  ) u_warm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_en    (mode_q[REF_BIT]),
    .hi_ref    (hi_ref),
    .ref_ready (ref_ready)
  );

  adc_conv_seq #(
    .UNIT (UNIT)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (mode_q[EN_BIT]),
    .rate_code    (rate_code),
    .ref_ready    (ref_ready),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .result_valid (result_valid),
    .cfg_error    (cfg_error)
  );

endmodule

// File: rtl/adc_ctl_seq_chk.sv
module adc_ctl_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_q,
  input logic       conv_start,
  input logic       conv_done,
  input logic       result_valid,
  input logic       ref_ready,
  input logic       cfg_error
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[6] == 1'b0) && (mode_q[2:1] == 2'b00));

  a_r4_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7] |=> (mode_q[5:3] == $past(mode_q[5:3])));

  a_r6_start_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> $past(mode_q[7]));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  a_r7_no_start_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !conv_start);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] |=> !ref_ready);

  a_r9_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> conv_done);

endmodule

bind adc_ctl_seq adc_ctl_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .conv_start   (conv_start),
  .conv_done    (conv_done),
  .result_valid (result_valid),
  .ref_ready    (ref_ready),
  .cfg_error    (cfg_error)
);

// File: tb/adc_ctl_seq_test.sv
module adc_ctl_seq_test;

  localparam int UNIT = 2;
  localparam int WN   = 17;
  localparam int WH   = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_set = 1'b0;
  logic       bit_clr = 1'b0;
  logic [2:0] bit_idx = '0;
  logic       rd_en = 1'b1;
  logic       hi_ref = 1'b0;
  logic [7:0] rd_data;
  logic       conv_start, conv_done, result_valid, ref_ready, cfg_error;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_ctl_seq #(.UNIT(UNIT), .WARM_NORM(WN), .WARM_HI(WH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
    .rd_en(rd_en), .rd_data(rd_data), .hi_ref(hi_ref),
    .conv_start(conv_start), .conv_done(conv_done),
    .result_valid(result_valid), .ref_ready(ref_ready), .cfg_error(cfg_error)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench restatement of the register rules (R2, R3, R4)
  function automatic logic [7:0] ref_model(input logic [7:0] prev, input logic wr,
      input logic [7:0] d, input logic s, input logic c, input logic [2:0] i);
    logic [7:0] r;
    if (wr)     r = d;
    else if (s) r = prev | (8'd1 << i);
    else if (c) r = prev & ~(8'd1 << i);
    else        r = prev;
    r = r & 8'hB9;
    if (prev[7]) r = (r & 8'hC7) | (prev & 8'h38);
    return r;
  endfunction

  function automatic int len_of(input int code);
    int base[8] = '{288, 240, 192, 0, 144, 120, 96, 0};
    return base[code] * UNIT / 24;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic access(input logic w, input logic [7:0] d, input logic s,
                        input logic c, input logic [2:0] i);
    wr_en = w; wr_data = d; bit_set = s; bit_clr = c; bit_idx = i;
    step();
    wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    access(1'b1, v, 1'b0, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    do_reset();

    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 conv_done", conv_done, 0);
    chk("R1 result_valid", result_valid, 0);
    chk("R1 ref_ready", ref_ready, 0);
    chk("R1 cfg_error", cfg_error, 0);

    // R2 / R4 / R7: sweep of every byte value
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = ref_model(prev, 1'b1, 8'(v), 1'b0, 1'b0, 3'd0);
      wr_byte(8'(v));
      chk("R2_R4 byte write", rd_data, e);
      chk("R7 cfg_error", cfg_error, (e[5:3] == 3'b011 || e[5:3] == 3'b111) ? 1 : 0);
      prev = e;
    end
    rd_en = 1'b0;
    #1 chk("R2 read gated", rd_data, 0);
    rd_en = 1'b1;

    // R3: single-bit set then clear for every index
    do_reset();
    prev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = ref_model(prev, 1'b0, 8'h00, 1'b1, 1'b0, 3'(i));
      access(1'b0, 8'h00, 1'b1, 1'b0, 3'(i));
      chk("R3 bit set", rd_data, e);
      prev = e;
      e = ref_model(prev, 1'b0, 8'h00, 1'b0, 1'b1, 3'(i));
      access(1'b0, 8'h00, 1'b0, 1'b1, 3'(i));
      chk("R3 bit clear", rd_data, e);
      prev = e;
    end
    access(1'b1, 8'h08, 1'b1, 1'b0, 3'd0);
    chk("R3 byte write wins", rd_data, 8'h08);
    access(1'b0, 8'h00, 1'b1, 1'b1, 3'd4);
    chk("R3 set beats clear", rd_data, 8'h18);
    // R4: single-bit access to rate while running is ignored
    access(1'b0, 8'h00, 1'b1, 1'b0, 3'd7);
    access(1'b0, 8'h00, 1'b1, 1'b0, 3'd5);
    chk("R4 locked bit set", rd_data, 8'h98);

    // R5 / R6: conversion length of every legal code
    for (int c = 0; c < 8; c++) begin
      int n;
      if (len_of(c) == 0) continue;
      do_reset();
      wr_byte(8'h80 | 8'(c << 3));
      chk("R6 no start yet", conv_start, 0);
      step();
      chk("R6 first start", conv_start, 1);
      n = 0;
      do begin step(); n++; end while (!conv_done && n < 1000);
      chk("R5 conversion length", n, len_of(c));
      chk("R6 restart with done", conv_start, 1);
      chk("R9 cold result", result_valid, 0);
      n = 0;
      do begin step(); n++; end while (!conv_done && n < 1000);
      chk("R5 second length", n, len_of(c));
    end

    // R7: forbidden codes
    for (int k = 0; k < 2; k++) begin
      int starts;
      logic [7:0] v;
      v = (k == 0) ? 8'h98 : 8'hB8;
      do_reset();
      wr_byte(v);
      starts = 0;
      for (int t = 0; t < 40; t++) begin step(); starts += conv_start; end
      chk("R7 no starts", starts, 0);
      chk("R7 cfg_error", cfg_error, 1);
    end

    // R8: warm-up in both reference modes
    for (int h = 0; h < 2; h++) begin
      int n;
      do_reset();
      hi_ref = h[0];
      wr_byte(8'h01);
      n = 0;
      while (!ref_ready && n < 1000) begin step(); n++; end
      chk("R8 warm-up count", n, h ? WH : WN);
      access(1'b0, 8'h00, 1'b0, 1'b1, 3'd0);
      chk("R8 ready held one cycle", ref_ready, 1);
      step();
      chk("R8 ready cleared", ref_ready, 0);
    end
    hi_ref = 1'b0;

    // R9: valid flag across successive results after a cold enable
    begin
      int L, k, t, stray;
      do_reset();
      L = len_of(6);
      wr_byte(8'hB1);
      k = 0; t = 1; stray = 0;
      while (k < 4 && t < 1000) begin
        step(); t++;
        if (result_valid && !conv_done) stray++;
        if (conv_done) begin
          k++;
          chk("R6 done timing", t, 2 + k * L);
          chk("R9 result_valid", result_valid, ((1 + (k - 1) * L) > WN) ? 1 : 0);
        end
      end
      chk("R9 no stray valid", stray, 0);
    end

    // R10: stop mid-conversion
    begin
      int dones, starts;
      do_reset();
      wr_byte(8'hB0);
      step();
      chk("R10 running", conv_start, 1);
      step(); step();
      access(1'b0, 8'h00, 1'b0, 1'b1, 3'd7);
      dones = 0; starts = 0;
      for (int t = 0; t < 3 * len_of(6); t++) begin
        step(); dones += conv_done; starts += conv_start;
      end
      chk("R10 no done after stop", dones, 0);
      chk("R10 no start after stop", starts, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule